// File: doc/BRIEF.md
# EDO DRAM Device-Side Behavioural Model

A clocked, synthesizable stand-in for the device side of a 16-bit extended-data-out DRAM. It is used in simulation in place of a real memory, so that a DRAM controller can be checked against it. The system clock oversamples the row strobe, the two byte column strobes, write enable, output enable and the 9-bit multiplexed address. From the order of their edges the model decodes each memory cycle as a row open, a page access, a write, a read-modify-write, a RAS-only refresh or a CAS-before-RAS refresh. Data is kept in a small array of `2^ROW_BITS x 2^COL_BITS` 16-bit words. The row and column pins are folded by XOR into the row and column indices, so every address pin affects the location.

All pins pass through one sampling register, and each decoded edge acts on the next clock. A pin change is therefore visible at the outputs two clock edges later. Each byte lane is driven through a separate enable bit, which stands for that lane's tristate driver. Two sticky flags report protocol misuse by the controller. One reports a row left unrefreshed for too long. The other reports an access made before the power-up wake-up cycles have been seen.

Top module: `edo_dram_model`

## Requirements
- R1: A falling RAS while both CAS strobes are high opens the row given on the address pins. The same row is counted as refreshed, with or without a later column access, so a RAS-only cycle refreshes.
- R2: A falling RAS while either CAS is already low starts a CAS-before-RAS refresh. It refreshes the row named by the internal counter and ignores the address pins. Until RAS and both CAS are high again, no word is written and no lane is driven, even with WE low.
- R3: The internal CAS is low while either byte strobe is low. Its falling edge latches the column address.
- R4: Lane 0 (bits 7:0) is controlled by LCAS and lane 1 (bits 15:8) by UCAS. A lane is driven only while RAS is low, OE is low, WE is high and the lane holds read data. The data comes from its CAS falling, or from EDO hold.
- R5: A write happens at the later of the internal CAS fall and the WE fall, in an open row. It updates only the lanes whose CAS is low at that moment. A lane CAS that falls later with WE low writes that lane. A WE fall after a read (read-modify-write) overwrites the word.
- R6: Read data stays driven after CAS rises. It is replaced at the next internal CAS fall, and it is dropped when OE goes high or when RAS and both CAS are all high.
- R7: Each row and column location holds its own word. A word read returns the last data written to that location.
- R8: `refreshErr` rises and stays high once any row goes `REFRESH_LIMIT` clocks without a refresh.
- R9: `initErr` rises and stays high if a column access happens before `INIT_CYCLES` RAS falling edges have been seen since reset.
- R10: The refresh counter starts at zero and advances by one after each CAS-before-RAS cycle, wrapping at 512. Successive CAS-before-RAS cycles therefore walk all rows.
- R11: Reset leaves no lane driven, both error flags low and every stored word zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| rasN | input | 1 | Row strobe, active low |
| lcasN | input | 1 | Column strobe for lane 0, active low |
| ucasN | input | 1 | Column strobe for lane 1, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dqIn | input | DATA_W | Data driven by the controller |
| dqOut | output | DATA_W | Read data toward the controller |
| dqOe | output | 2 | Per-lane drive enable; a lane of dqOut is valid only while its bit is 1 |
| refreshErr | output | 1 | Sticky: a row exceeded the refresh interval |
| initErr | output | 1 | Sticky: access before wake-up cycles completed |

## Verification
The hardest state to reach from the pins is a row that silently misses refresh while the others stay fresh. Hitting it requires the internal counter to advance, and the counter cannot be read. The bench runs two passes of eight CAS-before-RAS cycles with a long idle gap between them and checks that no refresh error appears. A counter that stalled would leave a row unrefreshed and raise the flag. A further idle stretch then shows that the flag does rise and stay high.

// File: rtl/edo_pkg.sv
package edo_pkg;
  localparam int LANES = 2;

  typedef struct packed {
    logic             wrEn;
    logic [LANES-1:0] wrMask;
    logic             rdLoad;
  } memStrobe_t;
endpackage

// File: rtl/edo_ctrl.sv
module edo_ctrl
  import edo_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int ROW_BITS    = 3,
  parameter int COL_BITS    = 3,
  parameter int INIT_CYCLES = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         rasN,
  input  logic                         lcasN,
  input  logic                         ucasN,
  input  logic                         weN,
  input  logic                         oeN,
  input  logic [ADDR_W-1:0]            addr,
  output memStrobe_t                   strb,
  output logic [ROW_BITS+COL_BITS-1:0] memIdx,
  output logic [LANES-1:0]             laneEn,
  output logic                         refreshPulse,
  output logic [ROW_BITS-1:0]          refreshIdx,
  output logic                         initErr,
  output logic                         cbrActive
);
  localparam int CNT_W = $clog2(INIT_CYCLES + 1);

  // sampled pins (Q) and previous sample (P)
  logic              rasQ, rasP, weQ, weP, oeQ;
  logic [LANES-1:0]  casQ, casP;
  logic [ADDR_W-1:0] addrQ;

  // cycle state
  logic                rowOpen;
  logic [ROW_BITS-1:0] rowReg;
  logic [COL_BITS-1:0] colReg;
  logic [ADDR_W-1:0]   refCnt;
  logic [LANES-1:0]    laneValid;
  logic [CNT_W-1:0]    rasCount;

  function automatic logic [ROW_BITS-1:0] foldRow(input logic [ADDR_W-1:0] a);
    logic [ROW_BITS-1:0] r;
    r = '0;
    for (int i = 0; i < ADDR_W; i++) r[i % ROW_BITS] = r[i % ROW_BITS] ^ a[i];
    return r;
  endfunction

  function automatic logic [COL_BITS-1:0] foldCol(input logic [ADDR_W-1:0] a);
    logic [COL_BITS-1:0] c;
    c = '0;
    for (int i = 0; i < ADDR_W; i++) c[i % COL_BITS] = c[i % COL_BITS] ^ a[i];
    return c;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rasQ  <= 1'b1; rasP <= 1'b1;
      casQ  <= '1;   casP <= '1;
      weQ   <= 1'b1; weP  <= 1'b1;
      oeQ   <= 1'b1;
      addrQ <= '0;
    end else begin
      rasQ  <= rasN;  rasP <= rasQ;
      casQ  <= {ucasN, lcasN}; casP <= casQ;
      weQ   <= weN;   weP  <= weQ;
      oeQ   <= oeN;
      addrQ <= addr;
    end
  end

  logic             casAnyQ, casAnyP, rasFall, casFall, weFall, cycleEnd;
  logic [LANES-1:0] laneFall;
  logic [COL_BITS-1:0] curCol;

  always_comb begin
    casAnyQ  = (casQ != '1);
    casAnyP  = (casP != '1);
    rasFall  = rasP & ~rasQ;
    casFall  = casAnyQ & ~casAnyP;
    weFall   = weP & ~weQ;
    laneFall = casP & ~casQ;
    cycleEnd = rasQ & ~casAnyQ;
    curCol   = casFall ? foldCol(addrQ) : colReg;
    memIdx   = {rowReg, curCol};

    strb.rdLoad = rowOpen & weQ & casFall;
    strb.wrEn   = rowOpen & ~weQ & casAnyQ & (casFall | weFall | (|laneFall));
    strb.wrMask = (casFall | weFall) ? ~casQ : laneFall;

    refreshPulse = rasFall;
    refreshIdx   = casAnyQ ? foldRow(refCnt) : foldRow(addrQ);

    laneEn = {LANES{~rasQ & ~oeQ & weQ & ~cbrActive}} & laneValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowOpen   <= 1'b0;
      cbrActive <= 1'b0;
      rowReg    <= '0;
      colReg    <= '0;
      refCnt    <= '0;
      laneValid <= '0;
      rasCount  <= '0;
      initErr   <= 1'b0;
    end else begin
      if (rasFall && !casAnyQ) begin
        rowOpen <= 1'b1;
        rowReg  <= foldRow(addrQ);
      end else if (rasQ) begin
        rowOpen <= 1'b0;
      end

      if (rasFall && casAnyQ) begin
        cbrActive <= 1'b1;
        refCnt    <= refCnt + 1'b1;
      end else if (cycleEnd) begin
        cbrActive <= 1'b0;
      end

      if (casFall) colReg <= foldCol(addrQ);

      if (cycleEnd || oeQ)           laneValid <= '0;
      else if (rowOpen && weQ && casFall) laneValid <= ~casQ;
      else if (rowOpen && weQ)       laneValid <= laneValid | laneFall;

      if (rasFall && rasCount < CNT_W'(INIT_CYCLES)) rasCount <= rasCount + 1'b1;
      if (rowOpen && casFall && rasCount < CNT_W'(INIT_CYCLES)) initErr <= 1'b1;
    end
  end
endmodule

// File: rtl/edo_datapath.sv
module edo_datapath
  import edo_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ROW_BITS = 3,
  parameter int COL_BITS = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  memStrobe_t                   strb,
  input  logic [ROW_BITS+COL_BITS-1:0] memIdx,
  input  logic [DATA_W-1:0]            dqIn,
  output logic [DATA_W-1:0]            dqOut
);
  localparam int DEPTH  = 1 << (ROW_BITS + COL_BITS);
  localparam int LANE_W = DATA_W / LANES;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] dinQ;
  logic [DATA_W-1:0] holdReg;

  always_ff @(posedge clk) begin
    if (!rstN) dinQ <= '0;
    else       dinQ <= dqIn;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int i = 0; i < DEPTH; i++) mem[i][g*LANE_W +: LANE_W] <= '0;
      end else if (strb.wrEn && strb.wrMask[g]) begin
        mem[memIdx][g*LANE_W +: LANE_W] <= dinQ[g*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            holdReg <= '0;
    else if (strb.rdLoad) holdReg <= mem[memIdx];
  end

  assign dqOut = holdReg;
endmodule

// File: rtl/edo_refresh_monitor.sv
module edo_refresh_monitor #(
  parameter int ROW_BITS      = 3,
  parameter int REFRESH_LIMIT = 3000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                refreshPulse,
  input  logic [ROW_BITS-1:0] refreshIdx,
  output logic                refreshErr
);
  localparam int ROWS  = 1 << ROW_BITS;
  localparam int AGE_W = $clog2(REFRESH_LIMIT + 1);

  logic [ROWS-1:0] expired;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [AGE_W-1:0] age;
    always_ff @(posedge clk) begin
      if (!rstN)                                               age <= '0;
      else if (refreshPulse && refreshIdx == ROW_BITS'(r))     age <= '0;
      else if (age != AGE_W'(REFRESH_LIMIT))                   age <= age + 1'b1;
    end
    assign expired[r] = (age == AGE_W'(REFRESH_LIMIT));
  end

  always_ff @(posedge clk) begin
    if (!rstN)         refreshErr <= 1'b0;
    else if (|expired) refreshErr <= 1'b1;
  end
endmodule

// File: rtl/edo_dram_model.sv
module edo_dram_model
  import edo_pkg::*;
#(
  parameter int ADDR_W        = 9,
  parameter int DATA_W        = 16,
  parameter int ROW_BITS      = 3,
  parameter int COL_BITS      = 3,
  parameter int INIT_CYCLES   = 8,
  parameter int REFRESH_LIMIT = 3000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rasN,
  input  logic              lcasN,
  input  logic              ucasN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dqIn,
  output logic [DATA_W-1:0] dqOut,
  output logic [1:0]        dqOe,
  output logic              refreshErr,
  output logic              initErr
);
  memStrobe_t                   strb;
  logic [ROW_BITS+COL_BITS-1:0] memIdx;
  logic                         refreshPulse;
  logic [ROW_BITS-1:0]          refreshIdx;
  logic                         cbrActive;

  edo_ctrl #(
    .ADDR_W(ADDR_W), .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .INIT_CYCLES(INIT_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .rasN(rasN), .lcasN(lcasN), .ucasN(ucasN),
    .weN(weN), .oeN(oeN), .addr(addr), .strb(strb), .memIdx(memIdx),
    .laneEn(dqOe), .refreshPulse(refreshPulse), .refreshIdx(refreshIdx),
    .initErr(initErr), .cbrActive(cbrActive)
  );

  edo_datapath #(
    .DATA_W(DATA_W), .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)
  ) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .memIdx(memIdx), .dqIn(dqIn), .dqOut(dqOut)
  );

  edo_refresh_monitor #(
    .ROW_BITS(ROW_BITS), .REFRESH_LIMIT(REFRESH_LIMIT)
  ) u_refresh (
    .clk(clk), .rstN(rstN), .refreshPulse(refreshPulse), .refreshIdx(refreshIdx),
    .refreshErr(refreshErr)
  );
endmodule

// File: rtl/edo_dram_checker.sv
module edo_dram_checker
  import edo_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              rasN,
  input logic              lcasN,
  input logic              ucasN,
  input logic              weN,
  input logic              oeN,
  input logic [DATA_W-1:0] dqOut,
  input logic [1:0]        dqOe,
  input logic              refreshErr,
  input logic              initErr,
  input memStrobe_t        strb,
  input logic              cbrActive
);
  // R4: a driven lane implies RAS low, OE low, WE high one sample earlier
  a_r4_drive_needs_read: assert property (@(posedge clk) disable iff (!rstN)
    (|dqOe) |-> $past(!rasN && !oeN && weN));

  // R5: a write needs WE low and touches only lanes whose CAS was low
  a_r5_write_lanes: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |-> ($past(!weN) && ((strb.wrMask & $past({ucasN, lcasN})) == 2'b00)));

  // R2: no data transfer while a CAS-before-RAS refresh is in progress
  a_r2_cbr_no_access: assert property (@(posedge clk) disable iff (!rstN)
    cbrActive |-> (!strb.wrEn && !strb.rdLoad));

  // R6: held output data changes only after a read load
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.rdLoad) |-> $stable(dqOut));

  // R8: refresh error is sticky
  a_r8_refresh_sticky: assert property (@(posedge clk) disable iff (!rstN)
    refreshErr |=> refreshErr);

  // R9: init error is sticky
  a_r9_init_sticky: assert property (@(posedge clk) disable iff (!rstN)
    initErr |=> initErr);
endmodule

bind edo_dram_model edo_dram_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .rasN(rasN), .lcasN(lcasN), .ucasN(ucasN),
  .weN(weN), .oeN(oeN), .dqOut(dqOut), .dqOe(dqOe), .refreshErr(refreshErr),
  .initErr(initErr), .strb(strb), .cbrActive(cbrActive)
);

// File: tb/tb_edo_dram_model.sv
`timescale 1ns/1ps
module tb_edo_dram_model;
  logic        clk = 1'b0;
  logic        rstN;
  logic        rasN, lcasN, ucasN, weN, oeN;
  logic [8:0]  addr;
  logic [15:0] dqIn;
  logic [15:0] dqOut;
  logic [1:0]  dqOe;
  logic        refreshErr, initErr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  edo_dram_model #(.REFRESH_LIMIT(500)) dut (
    .clk(clk), .rstN(rstN), .rasN(rasN), .lcasN(lcasN), .ucasN(ucasN),
    .weN(weN), .oeN(oeN), .addr(addr), .dqIn(dqIn), .dqOut(dqOut),
    .dqOe(dqOe), .refreshErr(refreshErr), .initErr(initErr)
  );

  typedef struct packed {
    logic ras, lc, uc, we, oe;
    logic [8:0]  ad;
    logic [15:0] din;
    logic        chk;
    logic [1:0]  eOe;
    logic [15:0] eDq;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b1,1'b1,1'b0,1'b1, 9'd2, 16'h0000, 1'b1, 2'b00, 16'h0000}, // R1 open row 2
    '{1'b0,1'b0,1'b0,1'b0,1'b1, 9'd5, 16'hA5C3, 1'b1, 2'b00, 16'h0000}, // R5 word early write
    '{1'b0,1'b1,1'b1,1'b0,1'b1, 9'd5, 16'hA5C3, 1'b0, 2'b00, 16'h0000},
    '{1'b0,1'b0,1'b1,1'b0,1'b1, 9'd6, 16'h1111, 1'b0, 2'b00, 16'h0000}, // lane 0 write
    '{1'b0,1'b1,1'b1,1'b0,1'b1, 9'd6, 16'h1111, 1'b0, 2'b00, 16'h0000},
    '{1'b0,1'b1,1'b0,1'b0,1'b1, 9'd6, 16'h2200, 1'b0, 2'b00, 16'h0000}, // lane 1 write
    '{1'b0,1'b1,1'b1,1'b1,1'b1, 9'd6, 16'h0000, 1'b0, 2'b00, 16'h0000},
    '{1'b1,1'b1,1'b1,1'b1,1'b1, 9'd0, 16'h0000, 1'b1, 2'b00, 16'h0000},
    '{1'b0,1'b1,1'b1,1'b1,1'b0, 9'd2, 16'h0000, 1'b1, 2'b00, 16'h0000}, // R4 no CAS, no drive
    '{1'b0,1'b0,1'b0,1'b1,1'b0, 9'd5, 16'h0000, 1'b1, 2'b11, 16'hA5C3}, // R7 word read
    '{1'b0,1'b1,1'b1,1'b1,1'b0, 9'd5, 16'h0000, 1'b1, 2'b11, 16'hA5C3}, // R6 EDO hold
    '{1'b0,1'b0,1'b1,1'b1,1'b0, 9'd6, 16'h0000, 1'b1, 2'b01, 16'h0011}, // R4 lane 0 read
    '{1'b0,1'b0,1'b1,1'b1,1'b1, 9'd6, 16'h0000, 1'b1, 2'b00, 16'h0000}, // R6 OE high drops
    '{1'b0,1'b0,1'b1,1'b1,1'b0, 9'd6, 16'h0000, 1'b1, 2'b00, 16'h0000},
    '{1'b0,1'b1,1'b1,1'b1,1'b0, 9'd6, 16'h0000, 1'b0, 2'b00, 16'h0000},
    '{1'b0,1'b1,1'b0,1'b1,1'b0, 9'd6, 16'h0000, 1'b1, 2'b10, 16'h2200}, // R3 lane 1 opens CAS
    '{1'b0,1'b0,1'b0,1'b1,1'b0, 9'd6, 16'h0000, 1'b1, 2'b11, 16'h2211}, // late lane joins
    '{1'b1,1'b1,1'b1,1'b1,1'b0, 9'd6, 16'h0000, 1'b1, 2'b00, 16'h0000}, // R6 cycle end
    '{1'b1,1'b0,1'b0,1'b0,1'b1, 9'd2, 16'hFFFF, 1'b0, 2'b00, 16'h0000}, // CAS first
    '{1'b0,1'b0,1'b0,1'b0,1'b1, 9'd2, 16'hFFFF, 1'b1, 2'b00, 16'h0000}, // R2 CBR with WE low
    '{1'b0,1'b0,1'b0,1'b1,1'b0, 9'd2, 16'hFFFF, 1'b1, 2'b00, 16'h0000}, // R2 high-Z
    '{1'b1,1'b1,1'b1,1'b1,1'b1, 9'd0, 16'h0000, 1'b0, 2'b00, 16'h0000},
    '{1'b0,1'b1,1'b1,1'b1,1'b1, 9'd3, 16'h0000, 1'b1, 2'b00, 16'h0000}, // R1 RAS-only
    '{1'b1,1'b1,1'b1,1'b1,1'b1, 9'd0, 16'h0000, 1'b0, 2'b00, 16'h0000},
    '{1'b0,1'b1,1'b1,1'b1,1'b0, 9'd2, 16'h0000, 1'b0, 2'b00, 16'h0000},
    '{1'b0,1'b0,1'b0,1'b1,1'b0, 9'd5, 16'h0000, 1'b1, 2'b11, 16'hA5C3}, // R2 CBR wrote nothing
    '{1'b0,1'b0,1'b0,1'b0,1'b1, 9'd5, 16'h5A3C, 1'b1, 2'b00, 16'h0000}, // R5 late write (RMW)
    '{1'b0,1'b1,1'b1,1'b1,1'b0, 9'd5, 16'h0000, 1'b1, 2'b00, 16'h0000},
    '{1'b0,1'b0,1'b0,1'b1,1'b0, 9'd5, 16'h0000, 1'b1, 2'b11, 16'h5A3C}, // R5 RMW result
    '{1'b1,1'b1,1'b1,1'b1,1'b1, 9'd0, 16'h0000, 1'b0, 2'b00, 16'h0000},
    '{1'b0,1'b1,1'b1,1'b1,1'b0, 9'd4, 16'h0000, 1'b0, 2'b00, 16'h0000},
    '{1'b0,1'b0,1'b0,1'b1,1'b0, 9'd5, 16'h0000, 1'b1, 2'b11, 16'h0000}, // R7/R11 other row zero
    '{1'b1,1'b1,1'b1,1'b1,1'b1, 9'd0, 16'h0000, 1'b0, 2'b00, 16'h0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic r, input logic l, input logic u, input logic w,
                       input logic o, input logic [8:0] a, input logic [15:0] d);
    @(negedge clk);
    rasN = r; lcasN = l; ucasN = u; weN = w; oeN = o; addr = a; dqIn = d;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 9'd0, 16'h0);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cbr();
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 9'd0, 16'h0);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 9'd0, 16'h0);
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 9'd0, 16'h0);
    drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 9'd0, 16'h0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    rasN = 1'b1; lcasN = 1'b1; ucasN = 1'b1; weN = 1'b1; oeN = 1'b1;
    addr = '0; dqIn = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic [15:0] mask;
    doReset();
    #1;
    // R11: reset state
    check("R11 dqOe after reset", 32'(dqOe), 32'd0);
    check("R11 refreshErr after reset", 32'(refreshErr), 32'd0);
    check("R11 initErr after reset", 32'(initErr), 32'd0);

    // R9: access right after reset, before wake-up cycles
    drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 9'd0, 16'h0);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 9'd0, 16'h0);
    check("R9 early access flags", 32'(initErr), 32'd1);
    idle(4);
    check("R9 flag sticky", 32'(initErr), 32'd1);

    // R10 / R8: two passes of CBR keep every row fresh only if the counter walks
    doReset();
    for (int i = 0; i < 8; i++) cbr();
    idle(250);
    for (int i = 0; i < 8; i++) cbr();
    idle(250);
    check("R10 counter walks all rows", 32'(refreshErr), 32'd0);
    idle(450);
    check("R8 stale row flags", 32'(refreshErr), 32'd1);
    idle(20);
    check("R8 flag sticky", 32'(refreshErr), 32'd1);

    // table of protocol cycles (R1 R2 R3 R4 R5 R6 R7)
    doReset();
    for (int i = 0; i < 8; i++) cbr();
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].ras, VECS[i].lc, VECS[i].uc, VECS[i].we, VECS[i].oe, VECS[i].ad, VECS[i].din);
      if (VECS[i].chk) begin
        mask = {{8{VECS[i].eOe[1]}}, {8{VECS[i].eOe[0]}}};
        check($sformatf("R4 lane enable, table vec %0d", i), 32'(dqOe), 32'(VECS[i].eOe));
        check($sformatf("R7 lane data, table vec %0d", i), 32'(dqOut & mask), 32'(VECS[i].eDq & mask));
      end
    end
    check("R9 no flag after wake-up", 32'(initErr), 32'd0);
    finishRun();
  end
endmodule